// File: doc/BRIEF.md
# SPI Peripheral-Side Shift Engine with Frame Status

This block is the receiving end of an SPI link. It watches an externally generated serial clock, an active-low select and the controller's data line, all sampled with its own faster system clock. While selected it shifts incoming bits into a 16-bit register from the LSB end toward the MSB. At the same time it sends a word that was preloaded before the frame, most significant bit first. Clock polarity and phase come in as run-time inputs, so one instance serves all four SPI modes.

The frame is delimited by the select line, and its length is not fixed. When the frame ends, the block publishes the received word and the number of bits actually clocked. It also pulses frame-begin and frame-end strobes. A sticky overrun flag tells the consumer it was too slow: the flag is raised when a new frame begins before the previous result was acknowledged. While the select is high the block does nothing, even if other devices keep the shared clock and data lines busy.

Top module: `spi_shift_target`

## Requirements
- R1: After reset, rx_word_o, bit_count_o, overrun_o, miso_o, start_o, done_o and shift_en_o are all 0.
- R2: start_o is high for exactly one system cycle per falling edge of the synchronised select. done_o is high for exactly one cycle per rising edge.
- R3: While the select is high, start_o, shift_en_o and miso_o stay 0, and the published results do not change, whatever sck_i and mosi_i do.
- R4: The leading clock edge is rising when cpol_i=0 and falling when cpol_i=1. Data is sampled on the leading edge when cpha_i=0 and on the trailing edge when cpha_i=1. The output bit changes on the opposite edge.
- R5: Each sampled bit enters bit 0 and earlier bits move toward bit 15. One cycle after done_o, bits [n-1:0] of rx_word_o hold the n sampled bits, with the last one at bit 0.
- R6: miso_o sends tx_word_i starting at bit 15. In phase 0 that bit is present from the start of the frame. Each further bit appears on the edge that does not sample.
- R7: bit_count_o gives the number of sampling edges in the last frame, saturating at 16.
- R8: overrun_o is set when a frame begins while a published result is still unacknowledged. It stays set until ack_i is pulsed, and ack_i also clears the pending result.
- R9: tx_word_i is captured at frame begin. Changing it during the frame does not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sck_i |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| sck_i | input | 1 | Serial clock from controller |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from controller |
| miso_o | output | 1 | Serial data to controller, 0 when not selected |
| tx_word_i | input | 16 | Word to send in the next frame |
| ack_i | input | 1 | Consumer has taken the result |
| rx_word_o | output | 16 | Received word of the last frame |
| bit_count_o | output | 5 | Bits clocked in the last frame |
| start_o | output | 1 | Frame-begin strobe |
| done_o | output | 1 | Frame-end strobe |
| shift_en_o | output | 1 | High in the cycle a bit is sampled |
| overrun_o | output | 1 | Sticky late-acknowledge flag |

## Verification
The bench runs frames in all four modes, with lengths from 3 to 20 bits. A design with the sampling and launch edges swapped would either shift in the previous data bit or send each output bit half a clock late, which corrupts both words. A 20-bit frame checks that the count stops at 16; a counter that wraps would report 4. A skipped acknowledge must raise overrun on the next frame and only there. A final burst of clock and data activity with the select high must leave every strobe, the output line and the published result unchanged.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Decide whether a detected clock transition is the data-capture edge.
  function automatic logic is_capture(input logic pol, input logic pha,
                                      input logic rise, input logic fall);
    logic lead;
    logic trail;
    lead  = pol ? fall : rise;
    trail = pol ? rise : fall;
    return pha ? trail : lead;
  endfunction

  // Decide whether a detected clock transition is the data-launch edge.
  function automatic logic is_launch(input logic pol, input logic pha,
                                     input logic rise, input logic fall);
    logic lead;
    logic trail;
    lead  = pol ? fall : rise;
    trail = pol ? rise : fall;
    return pha ? lead : trail;
  endfunction

  // Increment that stops at the limit.
  function automatic int sat_inc(input int cur, input int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage1;
  logic [N-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/spi_tgt_edges.sv
module spi_tgt_edges
  import spi_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic sck_s,
  input  logic cs_s,
  output logic cs_active,
  output logic frame_begin,
  output logic frame_end,
  output logic capture_ev,
  output logic launch_ev
);
  logic prev_sck;
  logic prev_cs;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      prev_cs  <= 1'b1;
    end else begin
      prev_sck <= sck_s;
      prev_cs  <= cs_s;
    end
  end

  assign rise        = sck_s & ~prev_sck;
  assign fall        = ~sck_s & prev_sck;
  assign cs_active   = ~cs_s;
  assign frame_begin = prev_cs & ~cs_s;
  assign frame_end   = ~prev_cs & cs_s;
  assign capture_ev  = cs_active & is_capture(cpol_i, cpha_i, rise, fall);
  assign launch_ev   = cs_active & is_launch(cpol_i, cpha_i, rise, fall);

  // R2
  begin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_begin |=> !frame_begin);
  // R2
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  // R4
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture_ev && launch_ev));
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
  import spi_tgt_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_begin,
  input  logic          frame_end,
  input  logic          capture_ev,
  input  logic          launch_ev,
  input  logic          mosi_s,
  input  logic [W-1:0]  tx_word_i,
  output logic          out_bit,
  output logic [W-1:0]  rx_word_o,
  output logic [CW-1:0] bit_count_o
);
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg        <= '0;
      out_bit     <= 1'b0;
      cnt         <= '0;
      rx_word_o   <= '0;
      bit_count_o <= '0;
    end else begin
      if (frame_begin) begin
        sreg    <= tx_word_i;
        out_bit <= tx_word_i[W-1];
        cnt     <= '0;
      end else if (capture_ev) begin
        sreg <= {sreg[W-2:0], mosi_s};
        cnt  <= CW'(sat_inc(int'(cnt), W));
      end else if (launch_ev) begin
        out_bit <= sreg[W-1];
      end
      if (frame_end) begin
        rx_word_o   <= sreg;
        bit_count_o <= cnt;
      end
    end
  end

  // R7
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count_o <= CW'(W));
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rx_word_o) && $stable(bit_count_o));
  // R7
  count_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_begin |=> cnt == '0);
endmodule

// File: rtl/spi_shift_target.sv
module spi_shift_target #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          sck_i,
  input  logic          cs_n_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic [W-1:0]  tx_word_i,
  input  logic          ack_i,
  output logic [W-1:0]  rx_word_o,
  output logic [CW-1:0] bit_count_o,
  output logic          start_o,
  output logic          done_o,
  output logic          shift_en_o,
  output logic          overrun_o
);
  localparam logic [2:0] SYNC_RST = 3'b010; // {mosi, cs, sck}

  logic [2:0] raw_vec;
  logic [2:0] syn_vec;
  logic       sck_s, cs_s, mosi_s;
  logic       cs_active, frame_begin, frame_end, capture_ev, launch_ev;
  logic       out_bit;
  logic       pending;

  assign raw_vec = {mosi_i, cs_n_i, sck_i};

  spi_tgt_sync #(.N(3), .RST_VAL(SYNC_RST)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (syn_vec)
  );

  assign sck_s  = syn_vec[0];
  assign cs_s   = syn_vec[1];
  assign mosi_s = syn_vec[2];

  spi_tgt_edges i_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpol_i      (cpol_i),
    .cpha_i      (cpha_i),
    .sck_s       (sck_s),
    .cs_s        (cs_s),
    .cs_active   (cs_active),
    .frame_begin (frame_begin),
    .frame_end   (frame_end),
    .capture_ev  (capture_ev),
    .launch_ev   (launch_ev)
  );

  spi_tgt_shifter #(.W(W), .CW(CW)) i_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_begin (frame_begin),
    .frame_end   (frame_end),
    .capture_ev  (capture_ev),
    .launch_ev   (launch_ev),
    .mosi_s      (mosi_s),
    .tx_word_i   (tx_word_i),
    .out_bit     (out_bit),
    .rx_word_o   (rx_word_o),
    .bit_count_o (bit_count_o)
  );

  // Result bookkeeping toward the consumer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      pending   <= frame_end | (pending & ~ack_i);
      overrun_o <= ~ack_i & (overrun_o | (frame_begin & pending));
    end
  end

  assign miso_o     = cs_active & ~cs_n_i & out_bit;
  assign start_o    = frame_begin;
  assign done_o     = frame_end;
  assign shift_en_o = capture_ev;

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !shift_en_o && !start_o && !miso_o);
  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !overrun_o);
  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !ack_i |=> overrun_o);
  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(start_o));
endmodule

// File: tb/test_spi_shift_target.sv
module test_spi_shift_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;   // system cycles per half serial clock

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [15:0] tx_word = '0;
  logic        ack = 1'b0;
  logic [15:0] rx_word;
  logic [4:0]  bit_count;
  logic        start, done, shift_en, overrun;

  int n_checks = 0;
  int n_fail   = 0;
  int n_start  = 0;
  int n_done   = 0;
  bit exp_pend = 1'b0;
  bit exp_ovr  = 1'b0;

  typedef struct {
    logic [15:0] rx;
    logic [15:0] mask;
    int          cnt;
    bit          ovr;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_shift_target i_spi_shift_target (
    .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .cpha_i(cpha), .sck_i(sck),
    .cs_n_i(cs_n), .mosi_i(mosi), .miso_o(miso), .tx_word_i(tx_word),
    .ack_i(ack), .rx_word_o(rx_word), .bit_count_o(bit_count),
    .start_o(start), .done_o(done), .shift_en_o(shift_en), .overrun_o(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (start) n_start++;
    if (done)  n_done++;
  end

  // Monitor: pop the expected result once the frame is published.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        item_t it;
        @(negedge clk);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          chk((rx_word & it.mask) == it.rx, "R5", "rx word",
              32'(rx_word & it.mask), 32'(it.rx));
          chk(int'(bit_count) == it.cnt, "R7", "bit count",
              32'(bit_count), 32'(it.cnt));
          chk(overrun == it.ovr, "R8", "overrun at result",
              32'(overrun), 32'(it.ovr));
        end
      end
    end
  end

  // Driver: plays the controller side and queues the expected result.
  task automatic frame(input logic pol, input logic pha, input int n,
                       input logic [31:0] mv, input logic [15:0] tx,
                       input bit do_ack, input bit flip_tx);
    item_t       it;
    logic [15:0] got;
    logic [15:0] miso_exp;
    int          s0, d0;
    cpol = pol; cpha = pha; sck = pol; tx_word = tx; mosi = 1'b0;
    repeat (6) @(negedge clk);
    s0 = n_start; d0 = n_done;
    if (exp_pend) exp_ovr = 1'b1;
    it.mask = (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    it.rx   = mv[15:0] & it.mask;
    it.cnt  = (n > 16) ? 16 : n;
    it.ovr  = exp_ovr;
    sb_q.push_back(it);
    got = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    if (flip_tx) tx_word = ~tx;  // R9: late change must not matter
    for (int i = 0; i < n; i++) begin
      if (!pha) begin
        mosi = mv[n-1-i];
        repeat (HALF) @(negedge clk);
        if (i < 16) got = {got[14:0], miso};
        sck = ~sck;
        repeat (HALF) @(negedge clk);
        sck = ~sck;
      end else begin
        sck = ~sck;
        mosi = mv[n-1-i];
        repeat (HALF) @(negedge clk);
        if (i < 16) got = {got[14:0], miso};
        sck = ~sck;
        repeat (HALF) @(negedge clk);
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    if (n <= 16) begin
      miso_exp = tx >> (16 - n);
      chk(got == miso_exp, flip_tx ? "R9" : "R6", "miso stream",
          32'(got), 32'(miso_exp));
    end
    chk(n_start - s0 == 1 && n_done - d0 == 1, "R2", "strobes per frame",
        32'((n_start - s0) * 16 + (n_done - d0)), 32'h11);
    exp_pend = 1'b1;
    if (do_ack) begin
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
      exp_pend = 1'b0;
      exp_ovr  = 1'b0;
      chk(overrun == 1'b0, "R8", "overrun after ack", 32'(overrun), 32'd0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] keep_rx;
    logic [4:0]  keep_cnt;
    bit          noisy;
    int          d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rx_word == 0 && bit_count == 0 && overrun == 0 && miso == 0 &&
        !start && !done && !shift_en, "R1", "reset state",
        {rx_word, 3'b0, bit_count, 4'b0, overrun, miso, start, done}, 32'd0);

    // R4 R5 R6 across the four modes
    frame(1'b0, 1'b0, 16, 32'h0000A5C3, 16'h1234, 1'b1, 1'b0);
    frame(1'b0, 1'b1,  8, 32'h0000005A, 16'hC3F0, 1'b1, 1'b0);
    frame(1'b1, 1'b0, 12, 32'h00000B6D, 16'h9E37, 1'b1, 1'b0);
    frame(1'b1, 1'b1, 16, 32'h00003CA9, 16'hB1E5, 1'b1, 1'b1);
    // R8: skip acknowledge, next frame must flag overrun
    frame(1'b0, 1'b0,  5, 32'h00000015, 16'h8001, 1'b0, 1'b0);
    frame(1'b0, 1'b1,  7, 32'h00000066, 16'h7F00, 1'b1, 1'b0);
    frame(1'b1, 1'b1,  3, 32'h00000005, 16'hA000, 1'b1, 1'b0);
    // R7: longer than the register, count saturates
    frame(1'b0, 1'b0, 20, 32'h000F1E2D, 16'h5555, 1'b1, 1'b0);

    // R3: bus activity with select high
    keep_rx = rx_word; keep_cnt = bit_count; d0 = n_done; noisy = 1'b0;
    cpol = 1'b0; cpha = 1'b0;
    for (int k = 0; k < 40; k++) begin
      sck  = ~sck;
      mosi = k[1] ^ k[0];
      repeat (2) @(negedge clk);
      if (start || done || shift_en || miso) noisy = 1'b1;
    end
    repeat (6) @(negedge clk);
    chk(!noisy, "R3", "strobes or miso while idle", 32'(noisy), 32'd0);
    chk(rx_word == keep_rx && bit_count == keep_cnt && n_done == d0, "R3",
        "result changed while idle", {rx_word, 11'd0, bit_count},
        {keep_rx, 11'd0, keep_cnt});
    chk(sb_q.size() == 0, "R5", "results left unpublished", 32'(sb_q.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule